// File: doc/BRIEF.md
# Saturating Counter Data Memory

This block is the data store of a profiling engine, fused with the small amount of arithmetic that profiling code performs on stored counters. A caller issues one operation per cycle: a plain read, a plain write, or a read-modify-write that bumps a stored counter by one or by an operand. The counter width applies to each operation separately and can be anything from 2 to 16 bits. Saturating operations stop at the top of the range rather than rolling over. A separate circular mode wraps back to zero, for ring-buffer pointers.

Addresses are never added. A small set of base registers, loaded at program setup, each hold an aligned sub-array start and a size exponent. The physical address is the base ORed with the offset, after the offset has been trimmed to the sub-array size. Each response carries the resulting value and four predicates for branching: counter at ceiling, clamp occurred, equal to operand, and at least operand. The memory has a single port. A read-modify-write therefore holds that port for a second cycle, and the block withholds its ready signal during that cycle.

Top module: `satctr_mem`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `cfg_err` is 0. Every base register holds start 0 and exponent 8, which covers the whole memory.
- R2: The address is `base | (offset & (2^k - 1))`, where k is the selected base's exponent. Offset bits at or above bit k are ignored.
- R3: Op 1 (read) returns the stored word masked to the width. Op 2 (write) stores the operand masked to the width and gives no response. A response appears in the cycle that follows the second rising edge after acceptance.
- R4: Op 3 (saturating increment) never goes past 2^N-1. An increment made while the counter is already at 2^N-1 leaves it there and raises `rsp_clamp`.
- R5: Op 4 (circular increment) goes from 2^N-1 to 0 and never raises `rsp_clamp`.
- R6: Op 5 (saturating add) stores the smaller of old+operand and 2^N-1. `rsp_clamp` is raised only when the sum exceeds 2^N-1.
- R7: A `req_width` value below 2 acts as 2, and a value above 16 acts as 16.
- R8: On each response, `rsp_full` = (result == 2^N-1), `rsp_eq` = (result == operand) and `rsp_ge` = (result >= operand), where the result is the returned word.
- R9: In the cycle after a read-modify-write is accepted, `req_ready` is 0. Any later access to the same word sees the updated value.
- R10: `cfg_err` is 1 while any base has a nonzero bit below its own size. It clears once that base is reloaded aligned.
- R11: Ops 0, 6 and 7 produce no response and change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load one base register |
| base_idx | input | 2 | Base register to load |
| base_addr | input | 8 | Sub-array start |
| base_log2 | input | 4 | Sub-array size exponent |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | Operation can be accepted |
| req_op | input | 3 | 0 none, 1 read, 2 write, 3 sat inc, 4 wrap inc, 5 sat add |
| req_bsel | input | 2 | Base register select |
| req_offset | input | 8 | Offset inside the sub-array |
| req_operand | input | 16 | Write data, addend, compare value |
| req_width | input | 5 | Counter width N |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 16 | Read or updated value |
| rsp_full | output | 1 | Result equals 2^N-1 |
| rsp_clamp | output | 1 | Saturation occurred |
| rsp_eq | output | 1 | Result equals operand |
| rsp_ge | output | 1 | Result at least operand |
| cfg_err | output | 1 | A base register is misaligned |

## Verification
Some rules hold on every cycle, and the assertions watch those. Ready drops after each read-modify-write. A clamp is always reported at the ceiling. Equality implies at-least. A response only follows an accepted read or read-modify-write. Loading a misaligned base raises the error flag. Other behaviour only shows in directed scenarios checked against a shadow memory, so the bench's scoreboard covers it: the stored values, clamping and wrapping at various widths, trimming of the offset, clamping of the width setting, and the absence of side effects from unused codes.

// File: rtl/satctr_mem.sv
module satctr_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NBASE  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       base_we,
  input  logic [$clog2(NBASE)-1:0]   base_idx,
  input  logic [ADDR_W-1:0]          base_addr,
  input  logic [$clog2(ADDR_W+1)-1:0] base_log2,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2:0]                 req_op,
  input  logic [$clog2(NBASE)-1:0]   req_bsel,
  input  logic [ADDR_W-1:0]          req_offset,
  input  logic [DATA_W-1:0]          req_operand,
  input  logic [$clog2(DATA_W+1)-1:0] req_width,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       rsp_full,
  output logic                       rsp_clamp,
  output logic                       rsp_eq,
  output logic                       rsp_ge,
  output logic                       cfg_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LOG_W = $clog2(ADDR_W+1);
  localparam int WID_W = $clog2(DATA_W+1);
  localparam logic [2:0] OP_RD = 3'd1, OP_WR = 3'd2, OP_INC = 3'd3,
                         OP_WRAP = 3'd4, OP_ADD = 3'd5;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] b_addr [NBASE];
  logic [LOG_W-1:0]  b_lg   [NBASE];
  logic [ADDR_W-1:0] b_mask [NBASE];
  logic [NBASE-1:0]  mis;

  for (genvar i = 0; i < NBASE; i++) begin : g_base
    logic [LOG_W-1:0] lg;
    logic [ADDR_W:0]  full;
    assign lg        = (b_lg[i] > LOG_W'(ADDR_W)) ? LOG_W'(ADDR_W) : b_lg[i];
    assign full      = ((ADDR_W+1)'(1) << lg) - (ADDR_W+1)'(1);
    assign b_mask[i] = full[ADDR_W-1:0];
    assign mis[i]    = |(b_addr[i] & b_mask[i]);
  end
  assign cfg_err = |mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBASE; i++) begin
        b_addr[i] <= '0;
        b_lg[i]   <= LOG_W'(ADDR_W);
      end
    end else if (base_we) begin
      b_addr[base_idx] <= base_addr;
      b_lg[base_idx]   <= base_log2;
    end
  end

  logic [WID_W-1:0]  n_eff;
  logic [DATA_W:0]   max_full;
  logic [DATA_W-1:0] req_max;
  logic [ADDR_W-1:0] addr;
  logic              accept, is_rmw, has_rsp;

  assign n_eff    = (req_width < WID_W'(2)) ? WID_W'(2) :
                    (req_width > WID_W'(DATA_W)) ? WID_W'(DATA_W) : req_width;
  assign max_full = ((DATA_W+1)'(1) << n_eff) - (DATA_W+1)'(1);
  assign req_max  = max_full[DATA_W-1:0];
  assign addr     = b_addr[req_bsel] | (req_offset & b_mask[req_bsel]);
  assign accept   = req_valid && req_ready;
  assign is_rmw   = (req_op == OP_INC) || (req_op == OP_WRAP) || (req_op == OP_ADD);
  assign has_rsp  = is_rmw || (req_op == OP_RD);

  logic              s2_v;
  logic [2:0]        s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [DATA_W-1:0] s2_opnd, s2_max, rd_q;
  logic              s2_rmw;

  assign s2_rmw    = (s2_op == OP_INC) || (s2_op == OP_WRAP) || (s2_op == OP_ADD);
  assign req_ready = !(s2_v && s2_rmw);

  logic [DATA_W-1:0] old, res;
  logic [DATA_W:0]   sum;
  logic              clamp;

  always_comb begin
    old   = rd_q & s2_max;
    sum   = {1'b0, old} + ((s2_op == OP_ADD) ? {1'b0, s2_opnd} : (DATA_W+1)'(1));
    res   = old;
    clamp = 1'b0;
    case (s2_op)
      OP_INC, OP_ADD:
        if (sum > {1'b0, s2_max}) begin
          res   = s2_max;
          clamp = 1'b1;
        end else begin
          res = sum[DATA_W-1:0];
        end
      OP_WRAP: res = (old == s2_max) ? '0 : sum[DATA_W-1:0];
      default: res = old;
    endcase
  end

  always_ff @(posedge clk) begin
    if (s2_v && s2_rmw) mem[s2_addr] <= res;
    else if (accept && req_op == OP_WR) mem[addr] <= req_operand & req_max;
    if (accept) rd_q <= mem[addr];
    s2_op   <= req_op;
    s2_addr <= addr;
    s2_opnd <= req_operand;
    s2_max  <= req_max;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_full  <= 1'b0;
      rsp_clamp <= 1'b0;
      rsp_eq    <= 1'b0;
      rsp_ge    <= 1'b0;
    end else begin
      s2_v      <= accept && has_rsp;
      rsp_valid <= s2_v;
      if (s2_v) begin
        rsp_data  <= res;
        rsp_full  <= (res == s2_max);
        rsp_clamp <= clamp;
        rsp_eq    <= (res == s2_opnd);
        rsp_ge    <= (res >= s2_opnd);
      end
    end
  end
endmodule

// File: rtl/satctr_mem_chk.sv
module satctr_mem_chk #(
  parameter int ADDR_W = 8,
  parameter int NBASE  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        base_we,
  input logic [ADDR_W-1:0]           base_addr,
  input logic [$clog2(ADDR_W+1)-1:0] base_log2,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [2:0]                  req_op,
  input logic                        rsp_valid,
  input logic                        rsp_full,
  input logic                        rsp_clamp,
  input logic                        rsp_eq,
  input logic                        rsp_ge,
  input logic                        cfg_err
);
  logic acc_rmw, acc_rsp, base_bad;
  logic [ADDR_W:0] lmask;
  assign acc_rmw  = req_valid && req_ready && (req_op >= 3'd3) && (req_op <= 3'd5);
  assign acc_rsp  = acc_rmw || (req_valid && req_ready && req_op == 3'd1);
  assign lmask    = ((ADDR_W+1)'(1) << ((base_log2 > ($clog2(ADDR_W+1))'(ADDR_W)) ?
                     ($clog2(ADDR_W+1))'(ADDR_W) : base_log2)) - (ADDR_W+1)'(1);
  assign base_bad = base_we && |(base_addr & lmask[ADDR_W-1:0]);

  // R9
  stall_after_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rmw |=> !req_ready);
  // R4
  clamp_at_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_clamp |-> rsp_full);
  // R8
  eq_implies_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_eq |-> rsp_ge);
  // R3
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_rsp, 2));
  // R10
  misaligned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_bad |=> cfg_err);
endmodule

bind satctr_mem satctr_mem_chk #(.ADDR_W(ADDR_W), .NBASE(NBASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_addr(base_addr),
  .base_log2(base_log2), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_full(rsp_full),
  .rsp_clamp(rsp_clamp), .rsp_eq(rsp_eq), .rsp_ge(rsp_ge), .cfg_err(cfg_err));

// File: tb/tb_satctr_mem.sv
`timescale 1ns/1ps
module tb_satctr_mem;
  logic clk = 0, rst_n = 0;
  logic base_we = 0;
  logic [1:0] base_idx = 0, req_bsel = 0;
  logic [7:0] base_addr = 0, req_offset = 0;
  logic [3:0] base_log2 = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [15:0] req_operand = 0;
  logic [4:0] req_width = 0;
  logic rsp_valid, rsp_full, rsp_clamp, rsp_eq, rsp_ge, cfg_err;
  logic [15:0] rsp_data;

  satctr_mem dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] sm [256];
  logic [7:0] bb_addr [4];
  int bb_lg [4];
  logic [19:0] q_exp [$];
  string q_tag [$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (q_exp.size() == 0) begin
      checks++; fails++;
      $display("FAIL R11 unexpected response actual=%h expected=none", rsp_data);
    end else begin
      logic [19:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(t, {rsp_data, rsp_full, rsp_clamp, rsp_eq, rsp_ge}, {12'd0, e});
    end
  end

  task automatic load_base(int i, logic [7:0] a, int lg);
    @(negedge clk);
    base_we = 1; base_idx = 2'(i); base_addr = a; base_log2 = 4'(lg);
    bb_addr[i] = a; bb_lg[i] = lg;
    @(posedge clk); #1 base_we = 0;
  endtask

  task automatic issue(logic [2:0] op, int bs, logic [7:0] off, logic [15:0] opnd,
                       logic [4:0] w, string tag);
    int n;
    logic [16:0] mx17, s;
    logic [15:0] mx, old, r;
    logic [7:0] a, m;
    logic cl;
    n = (w < 2) ? 2 : (w > 16) ? 16 : int'(w);
    mx17 = (17'd1 << n) - 17'd1;
    mx = mx17[15:0];
    m = 8'((1 << (bb_lg[bs] > 8 ? 8 : bb_lg[bs])) - 1);
    a = bb_addr[bs] | (off & m);
    old = sm[a] & mx;
    r = old; cl = 0;
    case (op)
      3'd2: sm[a] = opnd & mx;
      3'd3, 3'd5: begin
        s = {1'b0, old} + ((op == 3'd5) ? {1'b0, opnd} : 17'd1);
        if (s > {1'b0, mx}) begin r = mx; cl = 1; end else r = s[15:0];
        sm[a] = r;
      end
      3'd4: begin r = (old == mx) ? 16'd0 : old + 16'd1; sm[a] = r; end
      default: ;
    endcase
    if (op == 3'd1 || (op >= 3'd3 && op <= 3'd5)) begin
      q_exp.push_back({r, r == mx, cl, r == opnd, r >= opnd});
      q_tag.push_back(tag);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_bsel = 2'(bs); req_offset = off;
    req_operand = opnd; req_width = w;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin bb_addr[i] = 0; bb_lg[i] = 8; end
    for (int i = 0; i < 256; i++) sm[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cfg_err", cfg_err, 0);

    // R2 address formation
    load_base(1, 8'h40, 4);
    @(negedge clk); chk("R10 aligned base", cfg_err, 0);
    issue(3'd2, 1, 8'h13, 16'd5, 5'd8, "R2");
    issue(3'd1, 0, 8'h43, 16'd5, 5'd8, "R2 combined address");
    issue(3'd1, 1, 8'hF3, 16'd5, 5'd8, "R2 high offset ignored");

    // R3 write masking, read
    issue(3'd2, 0, 8'h10, 16'h01FF, 5'd8, "R3");
    issue(3'd1, 0, 8'h10, 16'h00FF, 5'd16, "R3 masked write");
    issue(3'd1, 0, 8'h10, 16'h0000, 5'd4, "R3 masked read");

    // R4 saturating increment, R9 stall
    issue(3'd2, 0, 8'h20, 16'd6, 5'd3, "R4");
    issue(3'd3, 0, 8'h20, 16'd0, 5'd3, "R4 inc to ceiling");
    @(negedge clk); chk("R9 ready low after rmw", req_ready, 0);
    issue(3'd3, 0, 8'h20, 16'd0, 5'd3, "R4 clamp at ceiling");
    issue(3'd1, 0, 8'h20, 16'd7, 5'd3, "R9 read after rmw");

    // R5 wrap
    issue(3'd2, 0, 8'h21, 16'd2, 5'd2, "R5");
    issue(3'd4, 0, 8'h21, 16'd0, 5'd2, "R5 wrap to max");
    issue(3'd4, 0, 8'h21, 16'd0, 5'd2, "R5 wrap to zero");

    // R6 saturating add
    issue(3'd2, 0, 8'h22, 16'd10, 5'd4, "R6");
    issue(3'd5, 0, 8'h22, 16'd3, 5'd4, "R6 add no clamp");
    issue(3'd5, 0, 8'h22, 16'd5, 5'd4, "R6 add clamp");
    issue(3'd5, 0, 8'h22, 16'd0, 5'd4, "R6 add zero at max");

    // R7 width clamping
    issue(3'd2, 0, 8'h23, 16'hFFFF, 5'd0, "R7");
    issue(3'd1, 0, 8'h23, 16'd3, 5'd31, "R7 narrow and wide width");
    issue(3'd3, 0, 8'h23, 16'd0, 5'd1, "R7 width one acts as two");

    // R8 predicates
    issue(3'd1, 0, 8'h20, 16'd9, 5'd3, "R8 below operand");
    issue(3'd1, 0, 8'h20, 16'd7, 5'd3, "R8 equal operand");
    issue(3'd1, 0, 8'h20, 16'd3, 5'd3, "R8 above operand");
    drain();

    // R10 misaligned base
    load_base(2, 8'h41, 4);
    @(negedge clk); chk("R10 misaligned", cfg_err, 1);
    load_base(2, 8'h40, 4);
    @(negedge clk); chk("R10 cleared", cfg_err, 0);

    // R11 unused codes
    issue(3'd6, 0, 8'h20, 16'd0, 5'd3, "R11");
    issue(3'd7, 0, 8'h20, 16'd0, 5'd3, "R11");
    issue(3'd0, 0, 8'h20, 16'd0, 5'd3, "R11");
    drain();
    chk("R11 no response pending", 32'(q_exp.size()), 0);
    issue(3'd1, 0, 8'h20, 16'd7, 5'd3, "R11 word unchanged");
    drain();
    chk("R3 all responses seen", 32'(q_exp.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule